// File: doc/BRIEF.md
# Socket Supply and Ground Router

This block configures the power routing of a 40-pin device socket from a stream of already decoded commands. Two commands pick a pin layout, one for the programming voltage and one for the supply voltage. The block looks up the 8-bit layout ID in a pattern table that is set by parameters. It then sends the pattern out serially into a chain of external 8-bit shift registers and closes the transfer with a single latch strobe. The programming-voltage chain has four registers and the supply-voltage chain has three. Each chain has its own clock, data and strobe pins.

A third command picks the one socket pin that is tied to ground. The block checks that the pin can be grounded. It then presents an offset code to the external ground-driver chips. A fourth command switches the socket pull-ups on or off. Illegal requests produce a one-cycle error pulse and leave the current setting unchanged. While a serial transfer is running the block reports busy and drops every command it is given.

Command codes on `cmd_op` are:
- 0 loads a programming-voltage layout.
- 1 loads a supply-voltage layout.
- 2 selects the grounded pin.
- 3 sets the pull-ups.

Top module: `sock_supply_router`

## Requirements
- R1: While reset is held and right after reset, every shift clock, data and strobe output is 0, `busy` is 0, `cmd_err` is 0, `gnd_code` is 0 and `pullup_en` is 0.
- R2: An accepted command with `cmd_op`=0 sends the VPP_TABLE pattern for ID `cmd_arg` on `vpp_sdat`, most significant bit first. It produces exactly VPP_REGS*REG_BITS rising edges of `vpp_sclk` and then one `vpp_stb` pulse. Pattern i sits at bits [i*LEN +: LEN] of the table parameter.
- R3: An accepted command with `cmd_op`=1 does the same on the `vcc_*` outputs with the VCC_TABLE pattern and VCC_REGS*REG_BITS clock edges. The other chain stays silent.
- R4: The shift clock runs at 2*SHIFT_HALF system cycles per period. Data changes only on a falling edge of the shift clock, so it is steady across each rising edge and while the clock is high. The strobe follows the last falling edge, lasts one shift-clock period, and the shift clock is low for its whole length.
- R5: A layout ID at or above NUM_LAYOUTS sends an all-zero pattern with the normal number of clock edges and a strobe.
- R6: `busy` is high from the cycle after a layout command is accepted until its strobe ends, which is (LEN+1)*2*SHIFT_HALF cycles. Any command presented while busy has no effect: no transfer, no change of `gnd_code` or `pullup_en`, and no error.
- R7: A command with `cmd_op`=2 and an allowed pin P drives `gnd_code` = P-4 from the cycle after acceptance. The allowed pins are 5, 14-20, 24, 26-29 and 33-35.
- R8: Pin 0 means no pin is grounded and drives `gnd_code` = 0, with no offset applied.
- R9: A ground command for any other pin leaves `gnd_code` unchanged and raises `cmd_err` for exactly one cycle after acceptance.
- R10: A command with `cmd_op`=3 and argument 1 sets `pullup_en`, and argument 0 clears it. Any other argument leaves `pullup_en` unchanged and raises `cmd_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (0 VPP layout, 1 VCC layout, 2 ground pin, 3 pull-up) |
| cmd_arg | input | 8 | Layout ID, pin number or pull-up argument |
| busy | output | 1 | Serial transfer in progress; commands are dropped |
| cmd_err | output | 1 | One-cycle pulse for a rejected argument |
| gnd_code | output | 8 | Ground-select code for the ground-driver chips |
| pullup_en | output | 1 | Socket pull-up enable |
| vpp_sclk | output | 1 | Programming-voltage chain shift clock |
| vpp_sdat | output | 1 | Programming-voltage chain serial data |
| vpp_stb | output | 1 | Programming-voltage chain latch strobe |
| vcc_sclk | output | 1 | Supply-voltage chain shift clock |
| vcc_sdat | output | 1 | Supply-voltage chain serial data |
| vcc_stb | output | 1 | Supply-voltage chain latch strobe |

## Verification
The bench builds the block with NUM_LAYOUTS=3 and SHIFT_HALF=2. The short table makes IDs 3 and above (R5) reachable with small arguments. The two-cycle half period exercises the half-period counter's wrap and its hold between edges, which a one-cycle half period would skip. The register counts stay at 4 and 3, so the scoreboard sees 32-bit and 24-bit words and can catch a bit count that is off by one. The table entries are set to patterns with asymmetric ends, so a bit-order reversal or a missed first or last bit changes the received word.

// File: rtl/sock_router_pkg.sv
package sock_router_pkg;

  typedef enum logic [1:0] {
    OP_VPP_LAYOUT = 2'd0,
    OP_VCC_LAYOUT = 2'd1,
    OP_GND_PIN    = 2'd2,
    OP_PULLUP     = 2'd3
  } sock_op_e;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_SHIFT  = 2'd1,
    CH_STROBE = 2'd2
  } chain_state_e;

  // Socket pins that can be tied to ground; 0 stands for "none".
  function automatic logic gnd_pin_ok(input logic [7:0] pin);
    return pin inside {8'd0, 8'd5, [8'd14:8'd20], 8'd24,
                       [8'd26:8'd29], [8'd33:8'd35]};
  endfunction

endpackage

// File: rtl/layout_rom.sv
module layout_rom #(
  parameter int ID_W  = 8,
  parameter int WIDTH = 32,
  parameter int NUM   = 4,
  parameter logic [NUM*WIDTH-1:0] TABLE = '0
) (
  input  logic [ID_W-1:0]  id,
  output logic [WIDTH-1:0] pattern
);

  // Unknown IDs read as an all-zero pattern.
  always_comb begin
    pattern = '0;
    for (int i = 0; i < NUM; i++) begin
      if (id == ID_W'(i)) pattern = TABLE[i*WIDTH +: WIDTH];
    end
  end

endmodule

// File: rtl/shift_chain.sv
module shift_chain
  import sock_router_pkg::*;
#(
  parameter int LEN  = 32,
  parameter int HALF = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [LEN-1:0] pattern,
  output logic           busy,
  output logic           sclk,
  output logic           sdat,
  output logic           stb
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (LEN > 1) ? $clog2(LEN) : 1;

  chain_state_e   state_q, state_d;
  logic [HW-1:0]  hcnt_q, hcnt_d;
  logic           phase_q, phase_d;
  logic [BW-1:0]  bcnt_q, bcnt_d;
  logic [LEN-1:0] sreg_q, sreg_d;
  logic           half_end;

  assign half_end = (hcnt_q == HW'(HALF - 1));

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    phase_d = phase_q;
    bcnt_d  = bcnt_q;
    sreg_d  = sreg_q;
    case (state_q)
      CH_IDLE: begin
        if (start) begin
          sreg_d  = pattern;
          state_d = CH_SHIFT;
          hcnt_d  = '0;
          phase_d = 1'b0;
          bcnt_d  = '0;
        end
      end
      CH_SHIFT: begin
        if (half_end) begin
          hcnt_d = '0;
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            if (bcnt_q == BW'(LEN - 1)) begin
              state_d = CH_STROBE;
            end else begin
              sreg_d = {sreg_q[LEN-2:0], 1'b0};
              bcnt_d = bcnt_q + BW'(1);
            end
          end
        end else begin
          hcnt_d = hcnt_q + HW'(1);
        end
      end
      CH_STROBE: begin
        if (half_end) begin
          hcnt_d = '0;
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            state_d = CH_IDLE;
          end
        end else begin
          hcnt_d = hcnt_q + HW'(1);
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      hcnt_q  <= '0;
      phase_q <= 1'b0;
      bcnt_q  <= '0;
      sreg_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      phase_q <= phase_d;
      bcnt_q  <= bcnt_d;
      sreg_q  <= sreg_d;
    end
  end

  assign busy = (state_q != CH_IDLE);
  assign sclk = (state_q == CH_SHIFT) && phase_q;
  assign sdat = (state_q == CH_SHIFT) && sreg_q[LEN-1];
  assign stb  = (state_q == CH_STROBE);

  // R4
  strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> !sclk);

  // R4
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));

  // R6
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/gnd_select.sv
module gnd_select
  import sock_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] pin,
  output logic       reject,
  output logic [7:0] code
);

  logic [7:0] code_d;
  logic       legal;

  assign legal  = gnd_pin_ok(pin);
  assign reject = wr_en && !legal;

  always_comb begin
    code_d = code;
    if (wr_en && legal) code_d = (pin == 8'd0) ? 8'd0 : (pin - 8'd4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= 8'd0;
    else        code <= code_d;
  end

  // R9
  gnd_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 8'd0) || gnd_pin_ok(code + 8'd4));

  // R6
  gnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(code));

endmodule

// File: rtl/sock_supply_router.sv
module sock_supply_router
  import sock_router_pkg::*;
#(
  parameter int REG_BITS    = 8,
  parameter int VPP_REGS    = 4,
  parameter int VCC_REGS    = 3,
  parameter int NUM_LAYOUTS = 4,
  parameter int SHIFT_HALF  = 2,
  parameter logic [NUM_LAYOUTS*VPP_REGS*REG_BITS-1:0] VPP_TABLE =
    128'h0000_00FF_00FF_0000_F000_000F_8000_0001,
  parameter logic [NUM_LAYOUTS*VCC_REGS*REG_BITS-1:0] VCC_TABLE =
    96'h00_0FF0_F0F0_F0C0_0003_8000_01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_arg,
  output logic       busy,
  output logic       cmd_err,
  output logic [7:0] gnd_code,
  output logic       pullup_en,
  output logic       vpp_sclk,
  output logic       vpp_sdat,
  output logic       vpp_stb,
  output logic       vcc_sclk,
  output logic       vcc_sdat,
  output logic       vcc_stb
);

  localparam int VPP_LEN = VPP_REGS * REG_BITS;
  localparam int VCC_LEN = VCC_REGS * REG_BITS;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sock_op_e             op;
  logic                 accept;
  logic                 vpp_start, vcc_start, gnd_wr, pu_cmd, pu_bad;
  logic                 gnd_reject, vpp_busy, vcc_busy;
  logic [VPP_LEN-1:0]   vpp_pat;
  logic [VCC_LEN-1:0]   vcc_pat;
  logic                 pu_d, err_d;

  assign op        = sock_op_e'(cmd_op);
  assign busy      = vpp_busy || vcc_busy;
  assign accept    = cmd_valid && !busy;
  assign vpp_start = accept && (op == OP_VPP_LAYOUT);
  assign vcc_start = accept && (op == OP_VCC_LAYOUT);
  assign gnd_wr    = accept && (op == OP_GND_PIN);
  assign pu_cmd    = accept && (op == OP_PULLUP);
  assign pu_bad    = pu_cmd && (cmd_arg > 8'd1);

  layout_rom #(.ID_W(8), .WIDTH(VPP_LEN), .NUM(NUM_LAYOUTS), .TABLE(VPP_TABLE))
    u_vpp_rom (.id(cmd_arg), .pattern(vpp_pat));

  layout_rom #(.ID_W(8), .WIDTH(VCC_LEN), .NUM(NUM_LAYOUTS), .TABLE(VCC_TABLE))
    u_vcc_rom (.id(cmd_arg), .pattern(vcc_pat));

  shift_chain #(.LEN(VPP_LEN), .HALF(SHIFT_HALF)) u_vpp_chain (
    .clk(clk), .rst_n(rst_int_n), .start(vpp_start), .pattern(vpp_pat),
    .busy(vpp_busy), .sclk(vpp_sclk), .sdat(vpp_sdat), .stb(vpp_stb)
  );

  shift_chain #(.LEN(VCC_LEN), .HALF(SHIFT_HALF)) u_vcc_chain (
    .clk(clk), .rst_n(rst_int_n), .start(vcc_start), .pattern(vcc_pat),
    .busy(vcc_busy), .sclk(vcc_sclk), .sdat(vcc_sdat), .stb(vcc_stb)
  );

  gnd_select u_gnd (
    .clk(clk), .rst_n(rst_int_n), .wr_en(gnd_wr), .pin(cmd_arg),
    .reject(gnd_reject), .code(gnd_code)
  );

  always_comb begin
    pu_d  = pullup_en;
    if (pu_cmd && !pu_bad) pu_d = cmd_arg[0];
    err_d = gnd_reject || pu_bad;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pullup_en <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      pullup_en <= pu_d;
      cmd_err   <= err_d;
    end
  end

  // R6
  one_chain_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(vpp_busy && vcc_busy));

  // R10
  pullup_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(pu_cmd) |-> $stable(pullup_en));

  // R6
  no_err_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && $past(busy)) |-> !cmd_err);

endmodule

// File: tb/tb_sock_supply_router.sv
module tb_sock_supply_router;

  localparam int H   = 2;
  localparam int NL  = 3;
  localparam int VPL = 32;
  localparam int VCL = 24;
  localparam logic [NL*VPL-1:0] VPP_T = {32'h1234_5678, 32'h8000_0001, 32'hA5C3_0F81};
  localparam logic [NL*VCL-1:0] VCC_T = {24'h3C_A596, 24'h80_0001, 24'hF0_0F5A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic busy, cmd_err, pullup_en;
  logic [7:0] gnd_code;
  logic vpp_sclk, vpp_sdat, vpp_stb, vcc_sclk, vcc_sdat, vcc_stb;

  always #4 clk = ~clk;

  sock_supply_router #(
    .NUM_LAYOUTS(NL), .SHIFT_HALF(H), .VPP_TABLE(VPP_T), .VCC_TABLE(VCC_T)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .busy(busy), .cmd_err(cmd_err), .gnd_code(gnd_code),
    .pullup_en(pullup_en), .vpp_sclk(vpp_sclk), .vpp_sdat(vpp_sdat),
    .vpp_stb(vpp_stb), .vcc_sclk(vcc_sclk), .vcc_sdat(vcc_sdat), .vcc_stb(vcc_stb)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [VPL-1:0] vpp_q[$];
  logic [VCL-1:0] vcc_q[$];

  function automatic logic [VPL-1:0] vpp_exp(input int id);
    return (id < NL) ? VPP_T[id*VPL +: VPL] : '0;
  endfunction
  function automatic logic [VCL-1:0] vcc_exp(input int id);
    return (id < NL) ? VCC_T[id*VCL +: VCL] : '0;
  endfunction

  // Monitor: VPP chain
  logic [VPL-1:0] vp_bits = '0;
  int vp_n = 0, vp_w = 0;
  logic vp_ck_p = 1'b0, vp_d_p = 1'b0, vp_s_p = 1'b0;
  always @(negedge clk) begin
    if (vpp_sclk && !vp_ck_p) begin
      chk(vpp_sdat == vp_d_p, "R4 vpp data steady at rise", vpp_sdat, vp_d_p);
      vp_bits = {vp_bits[VPL-2:0], vpp_sdat};
      vp_n++;
    end
    if (vpp_sclk && vp_ck_p && vpp_sdat != vp_d_p)
      chk(1'b0, "R4 vpp data moved while clock high", vpp_sdat, vp_d_p);
    if (vpp_stb) begin
      if (vpp_sclk) chk(1'b0, "R4 vpp clock high in strobe", 1, 0);
      if (!vp_s_p) begin
        if (vpp_q.size() == 0) chk(1'b0, "R6 unexpected vpp strobe", vp_bits, 0);
        else begin
          logic [VPL-1:0] e;
          e = vpp_q.pop_front();
          chk(vp_bits == e, "R2 vpp word", vp_bits, e);
          chk(vp_n == VPL, "R2 vpp clock count", vp_n, VPL);
        end
        vp_n = 0;
      end
      vp_w++;
    end else if (vp_s_p) begin
      chk(vp_w == 2*H, "R4 vpp strobe width", vp_w, 2*H);
      vp_w = 0;
    end
    vp_ck_p = vpp_sclk; vp_d_p = vpp_sdat; vp_s_p = vpp_stb;
  end

  // Monitor: VCC chain
  logic [VCL-1:0] vc_bits = '0;
  int vc_n = 0, vc_w = 0;
  logic vc_ck_p = 1'b0, vc_d_p = 1'b0, vc_s_p = 1'b0;
  always @(negedge clk) begin
    if (vcc_sclk && !vc_ck_p) begin
      chk(vcc_sdat == vc_d_p, "R4 vcc data steady at rise", vcc_sdat, vc_d_p);
      vc_bits = {vc_bits[VCL-2:0], vcc_sdat};
      vc_n++;
    end
    if (vcc_sclk && vc_ck_p && vcc_sdat != vc_d_p)
      chk(1'b0, "R4 vcc data moved while clock high", vcc_sdat, vc_d_p);
    if (vcc_stb) begin
      if (vcc_sclk) chk(1'b0, "R4 vcc clock high in strobe", 1, 0);
      if (!vc_s_p) begin
        if (vcc_q.size() == 0) chk(1'b0, "R3 unexpected vcc strobe", vc_bits, 0);
        else begin
          logic [VCL-1:0] e;
          e = vcc_q.pop_front();
          chk(vc_bits == e, "R3 vcc word", vc_bits, e);
          chk(vc_n == VCL, "R3 vcc clock count", vc_n, VCL);
        end
        vc_n = 0;
      end
      vc_w++;
    end else if (vc_s_p) begin
      chk(vc_w == 2*H, "R4 vcc strobe width", vc_w, 2*H);
      vc_w = 0;
    end
    vc_ck_p = vcc_sclk; vc_d_p = vcc_sdat; vc_s_p = vcc_stb;
  end

  task automatic send(input logic [1:0] op, input logic [7:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(input int exp_cycles, input string req);
    int n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_cycles, req, n, exp_cycles);
  endtask

  task automatic layout(input bit is_vcc, input int id);
    if (is_vcc) vcc_q.push_back(vcc_exp(id));
    else        vpp_q.push_back(vpp_exp(id));
    send(is_vcc ? 2'd1 : 2'd0, 8'(id));
    wait_idle(is_vcc ? (VCL+1)*2*H : (VPL+1)*2*H, "R6 busy length");
  endtask

  task automatic gnd(input int pin, input int exp_code, input bit exp_err, input string req);
    send(2'd2, 8'(pin));
    chk(gnd_code == 8'(exp_code), req, gnd_code, exp_code);
    chk(cmd_err == exp_err, {req, " err"}, cmd_err, exp_err);
    @(negedge clk);
    chk(cmd_err == 1'b0, {req, " err one cycle"}, cmd_err, 0);
  endtask

  task automatic pull(input int arg, input bit exp_pu, input bit exp_err);
    send(2'd3, 8'(arg));
    chk(pullup_en == exp_pu, "R10 pullup", pullup_en, exp_pu);
    chk(cmd_err == exp_err, "R10 err", cmd_err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({busy, cmd_err, pullup_en, vpp_sclk, vpp_sdat, vpp_stb, vcc_sclk, vcc_sdat, vcc_stb} == 9'd0,
        "R1 outputs in reset", 0, 0);
    chk(gnd_code == 8'd0, "R1 gnd_code in reset", gnd_code, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, cmd_err, pullup_en, vpp_sclk, vpp_stb, vcc_sclk, vcc_stb} == 7'd0,
        "R1 outputs after reset", 0, 0);

    // R2
    layout(1'b0, 0); layout(1'b0, 1); layout(1'b0, 2);
    // R3
    layout(1'b1, 0); layout(1'b1, 2); layout(1'b1, 1);
    // R5
    layout(1'b0, 200); layout(1'b1, 3);

    // R7
    gnd(5, 1, 0, "R7 pin5");   gnd(14, 10, 0, "R7 pin14"); gnd(20, 16, 0, "R7 pin20");
    gnd(26, 22, 0, "R7 pin26"); gnd(29, 25, 0, "R7 pin29"); gnd(33, 29, 0, "R7 pin33");
    gnd(35, 31, 0, "R7 pin35");
    // R8
    gnd(0, 0, 0, "R8 no ground");
    gnd(24, 20, 0, "R7 pin24");
    // R9
    gnd(4, 20, 1, "R9 pin4");   gnd(6, 20, 1, "R9 pin6");   gnd(13, 20, 1, "R9 pin13");
    gnd(21, 20, 1, "R9 pin21"); gnd(25, 20, 1, "R9 pin25"); gnd(30, 20, 1, "R9 pin30");
    gnd(36, 20, 1, "R9 pin36"); gnd(255, 20, 1, "R9 pin255");

    // R10
    pull(1, 1, 0); pull(2, 1, 1); pull(0, 0, 0); pull(255, 0, 1); pull(1, 1, 0);

    // R6: commands while busy are dropped
    vpp_q.push_back(vpp_exp(1));
    send(2'd0, 8'd1);
    send(2'd2, 8'd5);
    chk(cmd_err == 1'b0, "R6 no err while busy", cmd_err, 0);
    send(2'd3, 8'd0);
    send(2'd1, 8'd0);
    send(2'd2, 8'd99);
    chk(cmd_err == 1'b0, "R6 no err while busy", cmd_err, 0);
    wait_idle((VPL+1)*2*H - 8, "R6 busy length with dropped commands");
    chk(gnd_code == 8'd20, "R6 gnd kept", gnd_code, 20);
    chk(pullup_en == 1'b1, "R6 pullup kept", pullup_en, 1);
    repeat (4*VCL*H) @(negedge clk);
    chk(vcc_q.size() == 0 && vpp_q.size() == 0, "R6 scoreboard drained",
        vcc_q.size() + vpp_q.size(), 0);
    chk(busy == 1'b0 && vcc_sclk == 1'b0, "R6 no vcc transfer", busy, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule